// File: doc/BRIEF.md
# Link Request Header Framer

This block assembles the outgoing byte sequence for a single request on a DisplayPort AUX channel and feeds it to a downstream serializer. A request is described by its kind (native or I2C-over-AUX), a read/write flag, a middle-of-transaction flag, a status-request flag, a 20-bit address, a payload length, up to sixteen payload bytes and a start delay. When a request is accepted, the block first acknowledges the serializer's done flag from the previous transaction. It then waits until that flag has cleared. Next it streams the header bytes, and for writes the payload, on a valid/ready byte stream. Finally it pulses `go` together with the total byte count and the start delay.

The header is a command nibble plus the top four address bits, followed by the middle and low address bytes. An optional length byte holds the length minus one. For I2C-over-AUX requests the caller gives the 8-bit bus address, and the block moves it right by one bit before framing. A length above the payload limit is refused with a one-cycle error pulse, and nothing is sent.

Top module: `aux_req_framer`

## Requirements
- R1: After reset the block is idle, with `busy`, `done_ack`, `tx_valid`, `go` and `err` all low.
- R2: Byte 0 is the command nibble in bits 7:4 and address field bits 19:16 in bits 3:0. Byte 1 is address field bits 15:8, and byte 2 is address field bits 7:0.
- R3: The command nibble is 8 for a native write and 9 for a native read. For I2C it is 0 for a write, 1 for a read and 2 for a status request (status overrides the write flag), with bit 2 set when the middle-of-transaction flag is high. Native commands ignore the middle-of-transaction and status flags.
- R4: When the length is non-zero, byte 3 equals length minus one. A zero length produces exactly three bytes.
- R5: Write commands (native write, I2C write) append payload byte k, taken from `req_data[8k+7:8k]`, after the header. Reads and status requests append nothing. `tx_count` equals the number of bytes streamed.
- R6: For I2C requests the address field is `req_addr` shifted right by one bit. For native requests it is `req_addr` unchanged.
- R7: The cycle after an accepted start, `done_ack` is high for one cycle. No byte is offered until `done_flag` has been sampled low after that cycle.
- R8: The cycle after the last byte handshake, `go` is high for one cycle, with `tx_count` and `tx_delay` (the captured `req_delay`) valid.
- R9: A start with `req_len` above 16 raises `err` for one cycle in the following cycle. No transaction starts.
- R10: A start while `busy` is high is ignored and does not disturb the transaction in progress.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| req_i2c | input | 1 | 1 = I2C-over-AUX, 0 = native |
| req_write | input | 1 | 1 = write |
| req_mot | input | 1 | Middle-of-transaction (I2C only) |
| req_stat | input | 1 | I2C status request |
| req_addr | input | 20 | Address (I2C: 8-bit bus address) |
| req_len | input | 5 | Payload length, 0 to 16 accepted |
| req_data | input | 128 | Payload, byte k at bits 8k+7:8k |
| req_delay | input | 4 | Start delay for the serializer |
| done_flag | input | 1 | Serializer done flag from the previous transaction |
| done_ack | output | 1 | One-cycle acknowledge of the done flag |
| tx_ready | input | 1 | Stream ready |
| tx_valid | output | 1 | Stream valid |
| tx_data | output | 8 | Stream byte |
| go | output | 1 | One-cycle launch pulse |
| tx_count | output | 5 | Total bytes of the request |
| tx_delay | output | 4 | Start delay passed through |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Oversize request refused |

## Verification
An accepted start shows as `busy` and `done_ack` one cycle later. Bytes appear no earlier than the cycle after `done_flag` is seen low, each byte advances only on a ready cycle, and `go` follows the last handshake by one cycle. A refused start produces `err` one cycle later. The bench's behavioural model steps on the same edges, and its expectations are compared against every output at each falling edge, where all these results are settled. The stimulus includes stalls on `tx_ready`, a `done_flag` held high for several cycles, and a second start issued during a transaction.

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int DLY_W   = 4,
  localparam int CNT_W  = $clog2(MAX_LEN + 5),
  localparam int PIX_W  = $clog2(MAX_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 req_i2c,
  input  logic                 req_write,
  input  logic                 req_mot,
  input  logic                 req_stat,
  input  logic [19:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_LEN*8-1:0] req_data,
  input  logic [DLY_W-1:0]     req_delay,
  input  logic                 done_flag,
  output logic                 done_ack,
  input  logic                 tx_ready,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic                 go,
  output logic [CNT_W-1:0]     tx_count,
  output logic [DLY_W-1:0]     tx_delay,
  output logic                 busy,
  output logic                 err
);
  typedef enum logic [2:0] {S_IDLE, S_ACK, S_WAIT, S_LOAD, S_GO} st_t;

  st_t                  st;
  logic [3:0]           cmd_q;
  logic [19:0]          af_q;
  logic [LEN_W-1:0]     len_q;
  logic [MAX_LEN*8-1:0] pay_q;
  logic [CNT_W-1:0]     idx;

  wire accept   = start && (st == S_IDLE);
  wire too_long = req_len > LEN_W'(MAX_LEN);
  wire is_wr    = req_write && !(req_i2c && req_stat);
  wire [3:0] cmd_in = req_i2c ? {1'b0, req_mot, req_stat, ~req_write & ~req_stat}
                              : {3'b100, ~req_write};
  wire [19:0] af_in = req_i2c ? {1'b0, req_addr[19:1]} : req_addr;
  wire [CNT_W-1:0] cnt_in = CNT_W'((req_len != 0) ? 4 : 3) + (is_wr ? CNT_W'(req_len) : '0);
  wire [CNT_W-1:0] pidx = idx - CNT_W'(4);

  assign busy     = st != S_IDLE;
  assign done_ack = st == S_ACK;
  assign tx_valid = st == S_LOAD;
  assign go       = st == S_GO;

  always_comb begin
    case (idx)
      CNT_W'(0): tx_data = {cmd_q, af_q[19:16]};
      CNT_W'(1): tx_data = af_q[15:8];
      CNT_W'(2): tx_data = af_q[7:0];
      CNT_W'(3): tx_data = 8'(len_q - LEN_W'(1));
      default:   tx_data = pay_q[pidx[PIX_W-1:0]*8 +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      err      <= 1'b0;
      idx      <= '0;
      cmd_q    <= '0;
      af_q     <= '0;
      len_q    <= '0;
      pay_q    <= '0;
      tx_count <= '0;
      tx_delay <= '0;
    end else begin
      err <= accept && too_long;
      case (st)
        S_IDLE: if (accept && !too_long) begin
          st       <= S_ACK;
          cmd_q    <= cmd_in;
          af_q     <= af_in;
          len_q    <= req_len;
          pay_q    <= req_data;
          tx_count <= cnt_in;
          tx_delay <= req_delay;
          idx      <= '0;
        end
        S_ACK:  st <= S_WAIT;
        S_WAIT: if (!done_flag) st <= S_LOAD;
        S_LOAD: if (tx_ready) begin
          idx <= idx + CNT_W'(1);
          if (idx == tx_count - CNT_W'(1)) st <= S_GO;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module aux_req_framer_chk #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] req_len,
  input logic             done_flag,
  input logic             done_ack,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             go,
  input logic [CNT_W-1:0] tx_count,
  input logic             busy,
  input logic             err
);
  p_ack_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_len <= LEN_W'(MAX_LEN)) |=> done_ack);
  p_wait_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(!done_flag));
  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_len > LEN_W'(MAX_LEN)) |=> (err && !busy));
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);
  p_go_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!tx_valid && !done_ack));
  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (tx_count >= CNT_W'(3) && tx_count <= CNT_W'(MAX_LEN + 4)));
endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len), .done_flag(done_flag),
  .done_ack(done_ack), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .go(go), .tx_count(tx_count), .busy(busy), .err(err));

// File: tb/aux_req_framer_test.sv
module aux_req_framer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic req_i2c = 0, req_write = 0, req_mot = 0, req_stat = 0;
  logic [19:0] req_addr = '0;
  logic [4:0] req_len = '0;
  logic [127:0] req_data = '0;
  logic [3:0] req_delay = '0;
  logic done_flag = 0, tx_ready = 0;
  logic done_ack, tx_valid, go, busy, err;
  logic [7:0] tx_data;
  logic [4:0] tx_count;
  logic [3:0] tx_delay;

  aux_req_framer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int ph = 0, mcnt = 0, mdly = 0;
  bit merr = 0, stall = 0, running = 0;
  logic [7:0] q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phases 0 idle, 1 ack, 2 wait, 3 stream, 4 launch
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin ph = 0; merr = 0; q.delete(); end
    else begin
      merr = 0;
      stall = (ph == 3) && !tx_ready;
      case (ph)
        0: if (start) begin
             if (req_len > 16) merr = 1;
             else begin
               int c, af; bit wr;
               wr = req_write && !(req_i2c && req_stat);
               if (!req_i2c) c = req_write ? 8 : 9;
               else c = (req_stat ? 2 : (req_write ? 0 : 1)) + (req_mot ? 4 : 0);
               af = req_i2c ? req_addr / 2 : req_addr;   // R6
               q.delete();
               q.push_back(8'(c * 16 + af / 65536));
               q.push_back(8'(af / 256));
               q.push_back(8'(af));
               if (req_len != 0) q.push_back(8'(req_len - 1));
               if (wr) for (int k = 0; k < req_len; k++) q.push_back(req_data[8*k +: 8]);
               mcnt = q.size(); mdly = req_delay; ph = 1;
             end
           end
        1: ph = 2;
        2: if (!done_flag) ph = 3;
        3: if (tx_ready) begin void'(q.pop_front()); if (q.size() == 0) ph = 4; end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && running) begin
    chk(busy === (ph != 0), "R10 busy", busy, ph != 0);
    chk(done_ack === (ph == 1), "R7 done_ack", done_ack, ph == 1);
    chk(tx_valid === (ph == 3), "R7 tx_valid", tx_valid, ph == 3);
    if (ph == 3) begin
      int pos;
      pos = mcnt - q.size();
      if (stall) chk(tx_data === q[0], "R11 held byte", tx_data, q[0]);
      else if (pos < 3) chk(tx_data === q[0], "R2 R3 R6 header", tx_data, q[0]);
      else if (pos == 3) chk(tx_data === q[0], "R4 length byte", tx_data, q[0]);
      else chk(tx_data === q[0], "R5 payload", tx_data, q[0]);
    end
    chk(go === (ph == 4), "R8 go", go, ph == 4);
    if (ph == 4) begin
      chk(tx_count === 5'(mcnt), "R5 count", tx_count, mcnt);
      chk(tx_delay === 4'(mdly), "R8 delay", tx_delay, mdly);
    end
    chk(err === merr, "R9 err", err, merr);
  end

  always @(negedge clk) tx_ready <= (cyc % 3) != 1;

  task automatic run_req(input bit i2c, wr, mot, st, input int a, ln, dl, hold, input bit poke);
    int n;
    @(negedge clk);
    req_i2c = i2c; req_write = wr; req_mot = mot; req_stat = st;
    req_addr = 20'(a); req_len = 5'(ln); req_delay = 4'(dl);
    for (int k = 0; k < 16; k++) req_data[8*k +: 8] = 8'(a + 29 * k + ln);
    done_flag = hold > 0; start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (ph != 0 && n < 200) begin
      @(negedge clk); n++;
      if (n == hold) done_flag = 0;
      if (poke && n == 2) begin start = 1; req_addr = ~req_addr; req_len = 5'd2; end
      if (poke && n == 3) start = 0;
    end
    done_flag = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs while and after reset
    chk(!busy && !done_ack && !tx_valid && !go && !err, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done_ack && !tx_valid && !go && !err, "R1 idle", busy, 0);
    running = 1;
    run_req(0, 1, 0, 0, 'hA5C3E, 3, 5, 0, 0);   // native write, R3 R5
    run_req(0, 0, 1, 1, 'h12345, 4, 2, 0, 0);   // native read, flags ignored R3
    run_req(0, 0, 0, 0, 'hF00D1, 0, 0, 0, 0);   // zero length R4
    run_req(1, 1, 1, 0, 'h000A0, 2, 7, 0, 0);   // I2C write MOT R6
    run_req(1, 0, 0, 0, 'h000A1, 1, 1, 0, 0);   // I2C read
    run_req(1, 1, 1, 1, 'h00050, 3, 3, 0, 0);   // I2C status request, no payload
    run_req(0, 1, 0, 0, 'h80001, 16, 15, 0, 0); // full payload
    run_req(0, 1, 0, 0, 'h00777, 17, 4, 0, 0);  // R9 reject
    run_req(0, 1, 0, 0, 'h00777, 31, 4, 0, 0);  // R9 reject
    run_req(0, 1, 0, 0, 'h54321, 2, 6, 6, 0);   // R7 done flag held
    run_req(0, 1, 0, 0, 'h0ABCD, 5, 9, 0, 1);   // R10 start while busy
    run_req(1, 0, 1, 0, 'h000FE, 0, 0, 3, 0);   // I2C zero-length MOT
    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule